// File: doc/BRIEF.md
# Controller Status Flags with Set/Clear Strobes

This block keeps the mode and error state of a serial peripheral controller: an operational-mode flag (cleared means the controller is being configured, set means it runs), a master-select flag, and six error flags covering mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Software never writes these flags directly. It writes a 16-bit strobe word in which every flag owns one bit that sets it and one bit that clears it; a zero in a strobe bit leaves its flag alone.

Error-detection logic elsewhere in the controller delivers one-cycle event pulses for five of the errors. Each pulse sets its flag only when the matching per-error enable from the control word is on. While any of the six error flags is set, an error interrupt request stays high until software clears the flags. A packed status view places every flag at a fixed bit position, together with a busy indication passed through from the shifter.

Top module: `status_flags_ctrl`

## Requirements
- R1: Reset (synchronous, active low) clears all eight flags, so the status view reads 0x0000 apart from the busy bit and the error interrupt is low.
- R2: Strobe bit 1 sets and strobe bit 0 clears the operational-mode flag, shown at status bit 0.
- R3: Strobe bit 3 sets and strobe bit 2 clears the master-select flag, shown at status bit 1.
- R4: The error flags use these (clear, set) strobe bits and status bits: mode error 6/7 at bit 7, transmit overflow 8/12 at bit 8, receive overflow 9/13 at bit 9, abort 10/14 at bit 10, transmit underflow 11/15 at bit 11, receive underflow 4/5 at bit 12.
- R5: Event input bits 0..4 (transmit overflow, receive overflow, abort, transmit underflow, receive underflow) set status bits 8..12 one cycle later only when the same bit of the enable input is 1; with the enable at 0 the event leaves the flag unchanged.
- R6: The error interrupt is high exactly while any of status bits 7..12 is set, stays high across idle cycles, and is not raised by the mode or master-select flags.
- R7: Writing the set and clear strobe of one flag in the same word leaves that flag unchanged.
- R8: An enabled hardware event in the same cycle as a software clear of that flag leaves the flag set.
- R9: Status bit 13 follows the busy input in the same cycle; status bits 2..6, 14 and 15 read zero.
- R10: The strobe read-back output is always zero.
- R11: Strobe data presented while the write enable is low changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_we | input | 1 | Write enable for the strobe word |
| strobe_data | input | 16 | Strobe word, write-one set/clear bits |
| hw_err_evt | input | 5 | Error event pulses: tx overflow, rx overflow, abort, tx underflow, rx underflow |
| err_evt_en | input | 5 | Per-error enables from the control word, same order |
| busy_in | input | 1 | Shifter busy indication, passed to status bit 13 |
| status_word | output | 16 | Packed status view |
| strobe_rdata | output | 16 | Read-back of the strobe register, always zero |
| err_irq | output | 1 | Error interrupt request |

## Verification
Two functions can land on one flag in the same clock: an enabled hardware error event and a software clear strobe for that flag, and also the set and clear strobe of a single flag within one word. The bench drives both collisions deliberately on the same negative edge for several flags and judges the flag one edge later: the event must win over the clear, and the paired strobes must leave the previous value, tried from both the set and the cleared state.

// File: rtl/ssc_flag_pkg.sv
// Package: flag indices and bit positions shared by the status flag block.
// Assumes eight flags; index order is internal, positions are fixed by software.
package ssc_flag_pkg;
    localparam int NFLAG     = 8;
    localparam int NEVT      = 5;
    localparam int STROBE_W  = 16;
    localparam int STATUS_W  = 16;
    localparam int EVT_BASE  = 3;   // first flag index fed by a hardware event
    localparam int ERR_FIRST = 2;   // first error flag index
    localparam int BUSY_POS  = 13;

    // Flag indices: 0 op-mode, 1 master, 2 mode err, 3 tx ovf, 4 rx ovf,
    // 5 abort, 6 tx underflow, 7 rx underflow.

    // Strobe bit that sets flag f.
    function automatic int set_pos(input int f);
        case (f)
            0: set_pos = 1;
            1: set_pos = 3;
            2: set_pos = 7;
            3: set_pos = 12;
            4: set_pos = 13;
            5: set_pos = 14;
            6: set_pos = 15;
            default: set_pos = 5;
        endcase
    endfunction

    // Strobe bit that clears flag f.
    function automatic int clr_pos(input int f);
        case (f)
            0: clr_pos = 0;
            1: clr_pos = 2;
            2: clr_pos = 6;
            3: clr_pos = 8;
            4: clr_pos = 9;
            5: clr_pos = 10;
            6: clr_pos = 11;
            default: clr_pos = 4;
        endcase
    endfunction

    // Status view bit that shows flag f.
    function automatic int stat_pos(input int f);
        case (f)
            0: stat_pos = 0;
            1: stat_pos = 1;
            2: stat_pos = 7;
            3: stat_pos = 8;
            4: stat_pos = 9;
            5: stat_pos = 10;
            6: stat_pos = 11;
            default: stat_pos = 12;
        endcase
    endfunction
endpackage

// File: rtl/flag_strobe_decode.sv
// Module: turns a strobe write into per-flag set and clear requests.
// Assumes strobe bits are write-one; nothing is requested when we is low.
module flag_strobe_decode
    import ssc_flag_pkg::*;
#(
    parameter int NF = NFLAG,
    parameter int SW = STROBE_W
) (
    input  logic          we,
    input  logic [SW-1:0] data,
    output logic [NF-1:0] set_req,
    output logic [NF-1:0] clr_req
);
    for (genvar f = 0; f < NF; f++) begin : g_dec
        localparam int SP = set_pos(f);
        localparam int CP = clr_pos(f);
        // Pick the flag's own set and clear strobe bits.
        assign set_req[f] = we & data[SP];
        assign clr_req[f] = we & data[CP];
    end
endmodule

// File: rtl/flag_event_gate.sv
// Module: qualifies hardware error events with their enables and routes
// them to flag indices. Assumes event k belongs to flag BASE+k.
module flag_event_gate
    import ssc_flag_pkg::*;
#(
    parameter int NF   = NFLAG,
    parameter int NE   = NEVT,
    parameter int BASE = EVT_BASE
) (
    input  logic [NE-1:0] evt,
    input  logic [NE-1:0] en,
    output logic [NF-1:0] hw_set
);
    for (genvar f = 0; f < NF; f++) begin : g_gate
        if (f >= BASE && f < BASE + NE) begin : g_src
            // Enabled event sets this flag.
            assign hw_set[f] = evt[f-BASE] & en[f-BASE];
        end else begin : g_none
            // Flag has no hardware source.
            assign hw_set[f] = 1'b0;
        end
    end
endmodule

// File: rtl/flag_cell.sv
// Module: one status flag with hardware set, software set and software clear.
// Assumes hardware set wins; opposing software strobes cancel each other.
module flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_set,
    input  logic sw_clr,
    output logic q
);
    // Update the flag with hardware priority over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (hw_set) begin
            q <= 1'b1;
        end else if (sw_set && !sw_clr) begin
            q <= 1'b1;
        end else if (sw_clr && !sw_set) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/flag_status_pack.sv
// Module: places flags and busy into the status view and forms the error
// interrupt. Assumes flags from index ERR_FIRST upward are errors.
module flag_status_pack
    import ssc_flag_pkg::*;
#(
    parameter int NF = NFLAG,
    parameter int STW = STATUS_W,
    parameter int EF = ERR_FIRST
) (
    input  logic [NF-1:0]  flags,
    input  logic           busy,
    output logic [STW-1:0] word,
    output logic           irq
);
    // Scatter flags into their fixed view positions.
    always_comb begin
        word = '0;
        for (int f = 0; f < NF; f++) begin
            word[stat_pos(f)] = flags[f];
        end
        word[BUSY_POS] = busy;
    end

    // Any error flag raises the interrupt.
    assign irq = |flags[NF-1:EF];
endmodule

// File: rtl/status_flags_ctrl.sv
// Module: top of the status flag block. Holds the mode and error flags,
// changed by software strobes and gated hardware events, and drives the
// error interrupt. Assumes event pulses are synchronous to clk.
module status_flags_ctrl
    import ssc_flag_pkg::*;
#(
    parameter int SW  = STROBE_W,
    parameter int STW = STATUS_W,
    parameter int NE  = NEVT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe_we,
    input  logic [SW-1:0]  strobe_data,
    input  logic [NE-1:0]  hw_err_evt,
    input  logic [NE-1:0]  err_evt_en,
    input  logic           busy_in,
    output logic [STW-1:0] status_word,
    output logic [SW-1:0]  strobe_rdata,
    output logic           err_irq
);
    localparam int NF = NFLAG;

    logic [NF-1:0] set_req;
    logic [NF-1:0] clr_req;
    logic [NF-1:0] hw_set;
    logic [NF-1:0] flags;

    flag_strobe_decode #(.NF(NF), .SW(SW)) u_dec (
        .we      (strobe_we),
        .data    (strobe_data),
        .set_req (set_req),
        .clr_req (clr_req)
    );

    flag_event_gate #(.NF(NF), .NE(NE), .BASE(EVT_BASE)) u_gate (
        .evt    (hw_err_evt),
        .en     (err_evt_en),
        .hw_set (hw_set)
    );

    for (genvar f = 0; f < NF; f++) begin : g_flag
        flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (hw_set[f]),
            .sw_set (set_req[f]),
            .sw_clr (clr_req[f]),
            .q      (flags[f])
        );
    end

    flag_status_pack #(.NF(NF), .STW(STW), .EF(ERR_FIRST)) u_pack (
        .flags (flags),
        .busy  (busy_in),
        .word  (status_word),
        .irq   (err_irq)
    );

    // The strobe register is write-only.
    assign strobe_rdata = '0;
endmodule

// File: rtl/status_flags_chk.sv
// Module: assertion checker for status_flags_ctrl, bound to every instance.
module status_flags_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        strobe_we,
    input logic [15:0] strobe_data,
    input logic [4:0]  hw_err_evt,
    input logic [4:0]  err_evt_en,
    input logic [15:0] status_word,
    input logic        err_irq
);
    // R1: a reset cycle leaves every flag cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (status_word[12:0] == 13'h0));

    // R2: a lone set strobe turns on operational mode.
    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_we && strobe_data[1] && !strobe_data[0]) |=> status_word[0]);

    // R3: a lone clear strobe with no set drops master select.
    p_ms_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_we && strobe_data[2] && !strobe_data[3]) |=> !status_word[1]);

    // R4: mode-error set strobe shows at status bit 7.
    p_me_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_we && strobe_data[7] && !strobe_data[6]) |=> status_word[7]);

    // R5 and R8: an enabled event always leaves its flag set.
    for (genvar k = 0; k < 5; k++) begin : g_evt
        p_hw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_err_evt[k] && err_evt_en[k]) |=> status_word[8+k]);
    end

    // R6: interrupt mirrors the error flags.
    p_irq_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (|status_word[12:7]));

    // R7: paired strobes for operational mode hold it.
    p_pair_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_we && strobe_data[1] && strobe_data[0]) |=> $stable(status_word[0]));

    // R9: unused view bits stay zero.
    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[6:2] == 5'h0) && (status_word[15:14] == 2'h0));

    // R11: with no write and no enabled event, flags hold.
    p_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_we && ((hw_err_evt & err_evt_en) == 5'h0))
        |=> ($stable(status_word[12:0]) || $changed(status_word[13])));
endmodule

bind status_flags_ctrl status_flags_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_we   (strobe_we),
    .strobe_data (strobe_data),
    .hw_err_evt  (hw_err_evt),
    .err_evt_en  (err_evt_en),
    .status_word (status_word),
    .err_irq     (err_irq)
);

// File: tb/sim_status_flags_ctrl.sv
`timescale 1ns/1ps
module sim_status_flags_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_we = 1'b0;
    logic [15:0] strobe_data = '0;
    logic [4:0]  hw_err_evt = '0;
    logic [4:0]  err_evt_en = '0;
    logic        busy_in = 1'b0;
    logic [15:0] status_word;
    logic [15:0] strobe_rdata;
    logic        err_irq;

    always #4 clk = ~clk;

    status_flags_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .strobe_we(strobe_we), .strobe_data(strobe_data),
        .hw_err_evt(hw_err_evt), .err_evt_en(err_evt_en), .busy_in(busy_in),
        .status_word(status_word), .strobe_rdata(strobe_rdata), .err_irq(err_irq)
    );

    typedef struct {
        logic [15:0] st;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Positions from R2..R4: flag order op, master, mode, txovf, rxovf, abort, txund, rxund.
    int spos [8] = '{1, 3, 7, 12, 13, 14, 15, 5};
    int cpos [8] = '{0, 2, 6, 8, 9, 10, 11, 4};
    int vpos [8] = '{0, 1, 7, 8, 9, 10, 11, 12};
    logic [7:0] model = '0;

    function automatic exp_t expect_now(input logic bsy, input string tag);
        exp_t e;
        e.st = '0;
        for (int f = 0; f < 8; f++) e.st[vpos[f]] = model[f];
        e.st[13] = bsy;
        e.irq = |model[7:2];
        e.tag = tag;
        return e;
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic step(input logic we, input logic [15:0] strb, input logic [4:0] evt,
                        input logic [4:0] en, input logic bsy, input string tag);
        @(negedge clk);
        rst_n = 1'b1;
        strobe_we = we; strobe_data = strb; hw_err_evt = evt;
        err_evt_en = en; busy_in = bsy;
        for (int f = 0; f < 8; f++) begin
            logic hs, ss, cs;
            hs = (f >= 3) ? (evt[f-3] & en[f-3]) : 1'b0;
            ss = we & strb[spos[f]];
            cs = we & strb[cpos[f]];
            if (hs) model[f] = 1'b1;
            else if (ss && !cs) model[f] = 1'b1;
            else if (cs && !ss) model[f] = 1'b0;
        end
        exp_q.push_back(expect_now(bsy, tag));
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; strobe_we = 1'b0; strobe_data = '0;
        hw_err_evt = '0; busy_in = 1'b0;
        model = '0;
        exp_q.push_back(expect_now(1'b0, tag));
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (status_word !== e.st || err_irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s status=%h exp=%h irq=%b exp=%b",
                             e.tag, status_word, e.st, err_irq, e.irq);
                end
                n_run++;
                if (strobe_rdata !== 16'h0) begin
                    n_fail++;
                    $display("FAIL R10 strobe_rdata=%h exp=0000", strobe_rdata);
                end
            end
        end
    end

    initial begin
        do_reset("R1 reset");
        step(0, 16'h0, 0, 0, 0, "R1 idle after reset");
        step(1, 16'h0002, 0, 0, 0, "R2 set op-mode");
        step(1, 16'h0001, 0, 0, 0, "R2 clear op-mode");
        step(1, 16'h0008, 0, 0, 0, "R3 set master, R6 no irq");
        step(1, 16'h0002, 0, 0, 0, "R6 op+master no irq");
        step(1, 16'h0004, 0, 0, 0, "R3 clear master");
        for (int f = 2; f < 8; f++) begin
            step(1, 16'(1) << spos[f], 0, 0, 0, "R4 error set strobe");
            step(0, 16'h0, 0, 0, 0, "R6 irq held while idle");
            step(1, 16'(1) << cpos[f], 0, 0, 0, "R4 error clear strobe");
        end
        for (int k = 0; k < 5; k++) begin
            step(0, 16'h0, 5'(1) << k, 5'h0, 0, "R5 event ignored when disabled");
            step(0, 16'h0, 5'(1) << k, 5'h1F, 0, "R5 enabled event sets");
        end
        step(0, 16'h0, 0, 5'h1F, 0, "R6 irq persists");
        step(1, 16'h0F50, 0, 5'h1F, 0, "R6 clear all errors drops irq");
        step(1, 16'h0003, 0, 0, 0, "R7 pair on cleared op-mode");
        step(1, 16'h0002, 0, 0, 0, "R2 set op-mode again");
        step(1, 16'h0003, 0, 0, 0, "R7 pair on set op-mode");
        step(1, 16'h00C0, 0, 0, 0, "R7 pair on mode error");
        step(1, 16'h0100, 5'h01, 5'h01, 0, "R8 event beats clear, tx ovf");
        step(1, 16'h0010, 5'h10, 5'h10, 0, "R8 event beats clear, rx und");
        step(1, 16'h0400, 5'h04, 5'h00, 0, "R8 disabled event loses to clear");
        step(0, 16'h0, 0, 0, 1, "R9 busy shown");
        step(1, 16'hFFFF, 0, 0, 1, "R7 all pairs hold, R9 busy");
        step(0, 16'hFFFF, 0, 0, 0, "R11 no write enable");
        step(0, 16'h5555, 0, 0, 0, "R11 no write enable pattern");
        do_reset("R1 reset mid-run");
        step(0, 16'h0, 0, 0, 0, "R1 cleared after reset");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule